// File: doc/BRIEF.md
# Reset and Interrupt Priority Resolver

This block looks at every pending reset and interrupt request in a cycle and names the one source the processor should service next. The reset requests rank highest, in a fixed order. Below them are three non-maskable interrupt sources: the X interrupt, the illegal-opcode trap and the software interrupt. The maskable group ranks below those. A global I mask input gates the whole maskable group. A select field promotes one maskable source above the others in that group.

The winner is reported as a one-hot grant vector and as an encoded index. Both are registered. Index 0 through 5 are the fixed sources in priority order. Index 6+k is maskable source k. Maskable source IRQ_IDX (default 5) is the external active-low IRQ pin. Its request comes from level or edge conditioning inside the block. A small control write port sets the select code, the IRQ sensing mode and the clock-monitor enable. A one-shot input clears the X mask bit.

Top module: `irq_prio_resolver`

## Requirements
- R1: While reset is held and after it is released, no grant is asserted. The reset state of the controls is: select code 0101, IRQ in level mode, clock-monitor enable off, X mask set.
- R2: The fixed order, highest first, is: power-on/pin reset (index 0), clock-monitor reset (1), watchdog reset (2), X interrupt (3), illegal opcode (4), software interrupt (5). Every one of these outranks every maskable source (index 6+k).
- R3: A watchdog request is granted only while `cop_off_i` is low.
- R4: A clock-monitor request is ignored until a control write sets `ctl_cme_i` to 1.
- R5: An X interrupt request is ignored while the X mask is set. A pulse on `xmask_clr_i` clears the mask. Nothing can set the mask again until reset.
- R6: While `i_mask_i` is high, no maskable source is granted. Fixed sources are still granted.
- R7: With no promotion in effect, the lower maskable index wins.
- R8: A select code c that is below NUM_MASK and has maskable source c requesting makes source c win over all other maskable sources. If source c is idle, the order of R7 applies.
- R9: A select code of NUM_MASK or more leaves the maskable group in the order of R7.
- R10: In level mode, the IRQ source requests for as long as `irq_n_i` is low. Bit IRQ_IDX of `mreq_i` is ignored in both modes.
- R11: In edge mode, a high-to-low transition of `irq_n_i` is latched. The latched request stays pending while it is masked. It clears in the cycle it is granted, so a pin that stays low does not request again.
- R12: Requests are resolved one clock edge after they are presented. At most one grant bit is high. When `valid_o` is high, `idx_o` names the asserted grant bit. When `valid_o` is low, `idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_i | input | 1 | Power-on or external pin reset request |
| cmf_i | input | 1 | Clock-monitor failure request |
| cop_i | input | 1 | Watchdog timeout request |
| cop_off_i | input | 1 | Watchdog disable configuration bit |
| xirq_i | input | 1 | X interrupt request |
| illop_i | input | 1 | Illegal opcode trap request |
| swi_i | input | 1 | Software interrupt request |
| irq_n_i | input | 1 | External IRQ pin, active low |
| mreq_i | input | NUM_MASK | Maskable requests (bit IRQ_IDX unused) |
| i_mask_i | input | 1 | Global maskable-interrupt mask |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_sel_i | input | SEL_W | Promoted-source select code |
| ctl_edge_i | input | 1 | IRQ mode: 1 for edge, 0 for level |
| ctl_cme_i | input | 1 | Clock-monitor reset enable |
| xmask_clr_i | input | 1 | One-shot clear of the X mask |
| grant_o | output | 6+NUM_MASK | One-hot grant, registered |
| idx_o | output | clog2(6+NUM_MASK) | Encoded index of the granted source |
| valid_o | output | 1 | A grant is asserted |

## Verification
The assertions check these rules on every cycle:
- the grant is one-hot or zero, and the index agrees with it;
- a power-on request always wins the next cycle;
- a disabled watchdog never wins;
- the I mask keeps every maskable index off the output;
- the X mask never rises again once cleared.

The other rules need scenarios run by the bench:
- the complete fixed order;
- promotion with an in-range code and the fallback with an out-of-range code;
- the clock-monitor enable;
- level and edge handling of the IRQ pin, including a latched edge that survives masking and is consumed by one grant.

// File: rtl/rip_pkg.sv
package rip_pkg;
   localparam int NUM_FIXED = 6;
   typedef enum int {
      SRC_POR   = 0,
      SRC_CMF   = 1,
      SRC_COP   = 2,
      SRC_XIRQ  = 3,
      SRC_ILLOP = 4,
      SRC_SWI   = 5
   } fixed_src_e;
endpackage

// File: rtl/rip_prio_pick.sv
module rip_prio_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] win
);
   generate
      if (N < 1) begin : g_bad
         $error("rip_prio_pick: N must be at least 1");
      end
   endgenerate

   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign seen[i+1] = seen[i] | req[i];
      assign win[i]    = req[i] & ~seen[i];
   end
endmodule

// File: rtl/rip_mask_arb.sv
module rip_mask_arb #(
   parameter int N     = 10,
   parameter int SEL_W = 4
) (
   input  logic [N-1:0]     req,
   input  logic [SEL_W-1:0] sel,
   output logic [N-1:0]     win
);
   generate
      if (N > (1 << SEL_W)) begin : g_bad
         $error("rip_mask_arb: select field too narrow for N sources");
      end
   endgenerate

   logic [N-1:0] sel_hot;
   logic [N-1:0] fixed_win;
   logic         promoted;

   for (genvar i = 0; i < N; i++) begin : g_dec
      assign sel_hot[i] = (sel == SEL_W'(i));
   end

   rip_prio_pick #(.N(N)) u_fixed (
      .req (req),
      .win (fixed_win)
   );

   assign promoted = |(sel_hot & req);
   assign win      = promoted ? (sel_hot & req) : fixed_win;
endmodule

// File: rtl/rip_irq_cond.sv
module rip_irq_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_mode,
   input  logic irq_n,
   input  logic taken,
   output logic irq_req
);
   logic pin_q;
   logic latch_q;
   logic fall;

   assign fall = edge_mode & pin_q & ~irq_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q   <= 1'b1;
         latch_q <= 1'b0;
      end else begin
         pin_q <= irq_n;
         if (edge_mode)
            latch_q <= fall | (latch_q & ~taken);
         else
            latch_q <= 1'b0;
      end
   end

   assign irq_req = edge_mode ? latch_q : ~irq_n;
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
   import rip_pkg::*;
#(
   parameter  int NUM_MASK = 10,
   parameter  int SEL_W    = 4,
   parameter  int IRQ_IDX  = 5,
   parameter  int SEL_RST  = 5,
   localparam int NSRC     = NUM_FIXED + NUM_MASK,
   localparam int IDX_W    = $clog2(NSRC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                por_i,
   input  logic                cmf_i,
   input  logic                cop_i,
   input  logic                cop_off_i,
   input  logic                xirq_i,
   input  logic                illop_i,
   input  logic                swi_i,
   input  logic                irq_n_i,
   input  logic [NUM_MASK-1:0] mreq_i,
   input  logic                i_mask_i,
   input  logic                ctl_we_i,
   input  logic [SEL_W-1:0]    ctl_sel_i,
   input  logic                ctl_edge_i,
   input  logic                ctl_cme_i,
   input  logic                xmask_clr_i,
   output logic [NSRC-1:0]     grant_o,
   output logic [IDX_W-1:0]    idx_o,
   output logic                valid_o
);
   generate
      if (IRQ_IDX < 0 || IRQ_IDX >= NUM_MASK) begin : g_bad_irq
         $error("irq_prio_resolver: IRQ_IDX outside maskable group");
      end
      if (SEL_RST < 0 || SEL_RST >= (1 << SEL_W)) begin : g_bad_rst
         $error("irq_prio_resolver: SEL_RST does not fit select field");
      end
      if (NUM_MASK < 1) begin : g_bad_num
         $error("irq_prio_resolver: NUM_MASK must be at least 1");
      end
   endgenerate

   // control state
   logic [SEL_W-1:0] sel_q;
   logic             edge_q;
   logic             cme_q;
   logic             xmask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= SEL_W'(SEL_RST);
         edge_q <= 1'b0;
         cme_q  <= 1'b0;
      end else if (ctl_we_i) begin
         sel_q  <= ctl_sel_i;
         edge_q <= ctl_edge_i;
         cme_q  <= ctl_cme_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         xmask_q <= 1'b1;
      else if (xmask_clr_i)
         xmask_q <= 1'b0;
   end

   // fixed group gating
   logic [NUM_FIXED-1:0] fixed_req;
   always_comb begin
      fixed_req            = '0;
      fixed_req[SRC_POR]   = por_i;
      fixed_req[SRC_CMF]   = cmf_i & cme_q;
      fixed_req[SRC_COP]   = cop_i & ~cop_off_i;
      fixed_req[SRC_XIRQ]  = xirq_i & ~xmask_q;
      fixed_req[SRC_ILLOP] = illop_i;
      fixed_req[SRC_SWI]   = swi_i;
   end

   // IRQ pin conditioning
   logic irq_req;
   logic irq_taken;
   logic [NSRC-1:0] pick;

   assign irq_taken = pick[NUM_FIXED + IRQ_IDX];

   rip_irq_cond u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_mode (edge_q),
      .irq_n     (irq_n_i),
      .taken     (irq_taken),
      .irq_req   (irq_req)
   );

   // maskable group
   logic [NUM_MASK-1:0] mask_req;
   logic [NUM_MASK-1:0] mask_win;

   always_comb begin
      mask_req          = mreq_i;
      mask_req[IRQ_IDX] = irq_req;
      if (i_mask_i)
         mask_req = '0;
   end

   rip_mask_arb #(.N(NUM_MASK), .SEL_W(SEL_W)) u_marb (
      .req (mask_req),
      .sel (sel_q),
      .win (mask_win)
   );

   // final resolution: fixed group ranks above maskable winner
   rip_prio_pick #(.N(NSRC)) u_final (
      .req ({mask_win, fixed_req}),
      .win (pick)
   );

   logic [IDX_W-1:0] idx_c;
   always_comb begin
      idx_c = '0;
      for (int k = 0; k < NSRC; k++) begin
         if (pick[k])
            idx_c = IDX_W'(k);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_o <= '0;
         idx_o   <= '0;
         valid_o <= 1'b0;
      end else begin
         grant_o <= pick;
         idx_o   <= idx_c;
         valid_o <= |pick;
      end
   end
endmodule

// File: rtl/rip_chk.sv
module rip_chk #(
   parameter int NUM_FIXED = 6,
   parameter int NSRC      = 16,
   parameter int IDX_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             por_i,
   input logic             cop_off_i,
   input logic             i_mask_i,
   input logic             xmask_q,
   input logic [NSRC-1:0]  grant_o,
   input logic [IDX_W-1:0] idx_o,
   input logic             valid_o
);
   // R12
   onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R12
   idx_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> grant_o[idx_o]);

   // R2
   por_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      por_i |=> (valid_o && idx_o == '0));

   // R3
   cop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cop_off_i |=> !grant_o[2]);

   // R6
   imask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      i_mask_i |=> !(valid_o && int'(idx_o) >= NUM_FIXED));

   // R5
   xmask_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(xmask_q));
endmodule

bind irq_prio_resolver rip_chk #(
   .NUM_FIXED (rip_pkg::NUM_FIXED),
   .NSRC      (NSRC),
   .IDX_W     (IDX_W)
) u_rip_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .por_i     (por_i),
   .cop_off_i (cop_off_i),
   .i_mask_i  (i_mask_i),
   .xmask_q   (xmask_q),
   .grant_o   (grant_o),
   .idx_o     (idx_o),
   .valid_o   (valid_o)
);

// File: tb/irq_prio_resolver_bench.sv
module irq_prio_resolver_bench;
   localparam int NM    = 10;
   localparam int NF    = 6;
   localparam int NSRC  = NF + NM;
   localparam int IDX_W = 4;
   localparam int IRQ   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic por_i = 0, cmf_i = 0, cop_i = 0, cop_off_i = 0, xirq_i = 0;
   logic illop_i = 0, swi_i = 0, irq_n_i = 1, i_mask_i = 0;
   logic [NM-1:0] mreq_i = '0;
   logic ctl_we_i = 0, ctl_edge_i = 0, ctl_cme_i = 0, xmask_clr_i = 0;
   logic [3:0] ctl_sel_i = 4'd0;
   logic [NSRC-1:0]  grant_o;
   logic [IDX_W-1:0] idx_o;
   logic             valid_o;

   irq_prio_resolver u_irq_prio_resolver (
      .clk(clk), .rst_n(rst_n), .por_i(por_i), .cmf_i(cmf_i), .cop_i(cop_i),
      .cop_off_i(cop_off_i), .xirq_i(xirq_i), .illop_i(illop_i), .swi_i(swi_i),
      .irq_n_i(irq_n_i), .mreq_i(mreq_i), .i_mask_i(i_mask_i),
      .ctl_we_i(ctl_we_i), .ctl_sel_i(ctl_sel_i), .ctl_edge_i(ctl_edge_i),
      .ctl_cme_i(ctl_cme_i), .xmask_clr_i(xmask_clr_i),
      .grant_o(grant_o), .idx_o(idx_o), .valid_o(valid_o)
   );

   typedef struct {
      string           tag;
      logic [NSRC-1:0] g;
      int              idx;
      logic            v;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 0;

   // reference state, kept from the requirements
   logic [3:0] m_sel;
   logic       m_edge, m_cme, m_xmask, m_latch, m_pin;

   task automatic go(input string tag);
      logic [NF-1:0] f;
      logic [NM-1:0] mm;
      logic          irq_r, fall, taken;
      exp_t          e;
      f[0] = por_i;
      f[1] = cmf_i & m_cme;
      f[2] = cop_i & ~cop_off_i;
      f[3] = xirq_i & ~m_xmask;
      f[4] = illop_i;
      f[5] = swi_i;
      irq_r = m_edge ? m_latch : ~irq_n_i;
      mm = mreq_i;
      mm[IRQ] = irq_r;
      if (i_mask_i) mm = '0;
      e.tag = tag; e.v = 1'b0; e.idx = 0;
      for (int k = NF - 1; k >= 0; k--)
         if (f[k]) begin e.v = 1'b1; e.idx = k; end
      if (!e.v) begin
         if (int'(m_sel) < NM && mm[m_sel]) begin
            e.v = 1'b1; e.idx = NF + int'(m_sel);
         end else begin
            for (int k = NM - 1; k >= 0; k--)
               if (mm[k]) begin e.v = 1'b1; e.idx = NF + k; end
         end
      end
      e.g = e.v ? (NSRC'(1) << e.idx) : '0;
      exp_q.push_back(e);
      taken = e.v && (e.idx == NF + IRQ);
      fall  = m_edge & m_pin & ~irq_n_i;
      m_latch = m_edge ? (fall | (m_latch & ~taken)) : 1'b0;
      m_pin = irq_n_i;
      if (ctl_we_i) begin m_sel = ctl_sel_i; m_edge = ctl_edge_i; m_cme = ctl_cme_i; end
      if (xmask_clr_i) m_xmask = 1'b0;
      @(negedge clk);
   endtask

   task automatic quiet();
      {por_i, cmf_i, cop_i, cop_off_i, xirq_i, illop_i, swi_i, i_mask_i} = '0;
      irq_n_i = 1'b1; mreq_i = '0; ctl_we_i = 0; xmask_clr_i = 0;
   endtask

   // monitor: pop and compare after each rising edge
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_checks++;
         if (grant_o !== e.g || valid_o !== e.v || int'(idx_o) != e.idx) begin
            n_fail++;
            $display("FAIL %s: grant=%h idx=%0d valid=%b expected grant=%h idx=%0d valid=%b",
                     e.tag, grant_o, idx_o, valid_o, e.g, e.idx, e.v);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      m_sel = 4'b0101; m_edge = 0; m_cme = 0; m_xmask = 1; m_latch = 0; m_pin = 1;
      quiet();
      // R1: requests during reset produce no grant
      por_i = 1; mreq_i = '1;
      repeat (3) @(negedge clk);
      n_checks++;
      if (grant_o !== '0 || valid_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: grant=%h valid=%b expected grant=0 valid=0", grant_o, valid_o);
      end
      quiet();
      rst_n = 1'b1;
      @(negedge clk);

      go("R1 idle after reset");
      // R1 / R8: reset select code promotes the IRQ pin over mreq[0]
      mreq_i[0] = 1; irq_n_i = 0; go("R8 reset code promotes IRQ"); quiet();
      xirq_i = 1; go("R5 X masked after reset"); quiet();
      cmf_i = 1; go("R4 clock monitor off after reset"); quiet();
      cop_i = 1; cop_off_i = 1; go("R3 watchdog disabled"); quiet();
      cop_i = 1; go("R3 watchdog enabled"); quiet();
      xmask_clr_i = 1; go("R5 clear X mask"); quiet();
      xirq_i = 1; go("R5 X granted after clear"); quiet();
      xmask_clr_i = 1; xirq_i = 1; go("R5 second clear has no effect"); quiet();
      por_i = 1; cmf_i = 1; cop_i = 1; xirq_i = 1; illop_i = 1; swi_i = 1; mreq_i = '1;
      go("R2 power-on wins all"); quiet();
      cmf_i = 1; cop_i = 1; xirq_i = 1; go("R2 watchdog over X, cmf gated"); quiet();
      ctl_we_i = 1; ctl_sel_i = 4'd5; ctl_cme_i = 1; go("R4 enable clock monitor"); quiet();
      cmf_i = 1; cop_i = 1; go("R4 clock monitor granted"); quiet();
      illop_i = 1; swi_i = 1; mreq_i = '1; go("R2 illegal opcode over swi"); quiet();
      swi_i = 1; mreq_i = '1; go("R2 swi over maskable"); quiet();
      i_mask_i = 1; mreq_i = '1; irq_n_i = 0; go("R6 maskable blocked"); quiet();
      i_mask_i = 1; xirq_i = 1; mreq_i = 10'h0ff; go("R6 fixed still granted"); quiet();
      ctl_we_i = 1; ctl_sel_i = 4'd12; ctl_cme_i = 1; go("R9 write out-of-range code"); quiet();
      mreq_i[3] = 1; mreq_i[7] = 1; go("R9 fallback order"); quiet();
      mreq_i[9] = 1; mreq_i[4] = 1; go("R7 lower index wins"); quiet();
      ctl_we_i = 1; ctl_sel_i = 4'd7; ctl_cme_i = 1; go("R8 write code 7"); quiet();
      mreq_i[3] = 1; mreq_i[7] = 1; go("R8 promoted source 7"); quiet();
      mreq_i[3] = 1; mreq_i[8] = 1; go("R8 promoted idle, default order"); quiet();
      mreq_i[IRQ] = 1; go("R10 mreq bit of IRQ ignored"); quiet();
      irq_n_i = 0; go("R10 level request 1"); quiet();
      irq_n_i = 0; go("R10 level request 2"); quiet();
      ctl_we_i = 1; ctl_sel_i = 4'd7; ctl_cme_i = 1; ctl_edge_i = 1;
      go("R11 select edge mode"); quiet();
      go("R11 pin idle high");
      irq_n_i = 0; i_mask_i = 1; go("R11 edge latched while masked"); quiet();
      irq_n_i = 0; i_mask_i = 1; go("R11 still masked"); quiet();
      irq_n_i = 0; go("R11 latched edge granted"); quiet();
      irq_n_i = 0; go("R11 latch consumed, pin low"); quiet();
      irq_n_i = 0; mreq_i[IRQ] = 1; go("R10 mreq bit ignored in edge mode"); quiet();
      go("R12 trailing idle");
      go("R12 drain");

      repeat (2) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule